// File: doc/BRIEF.md
# Interrupt Request Latch and Priority Arbiter

This block sits between the interrupt sources of a small processor core and its sequencer. Each source raises a one-cycle event pulse, which sets a sticky pending bit for that source. Software owns a per-source enable mask and a global interrupt-disable flag. Software can also drop pending bits through a clear-only write port.

The core asserts a sampling strobe at each instruction boundary. On that clock edge the block forms the set of sources that are pending, enabled and not globally masked. If that set is not empty, the lowest-numbered source in it wins. In the next cycle the block emits a one-cycle accept pulse together with the winner's index and its 16-bit vector address. At the same edge it clears the winner's pending bit and sets the global disable flag, so nested interrupts are blocked. Requests that lose arbitration stay pending and compete again at the next strobe.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), req_o and en_o are all zero, gdis_o is 1 and accept_o is 0.
- R2: An evt_i pulse of one cycle on bit k sets req_o[k] at that clock edge, and the bit stays 1 afterwards until it is accepted or cleared by software.
- R3: At a clock edge, source k can be accepted only if sample_i is 1, req_o[k] is 1, en_o[k] is 1 and gdis_o is 0. If no source qualifies, accept_o stays 0 in the next cycle.
- R4: When several sources qualify at the same edge, the lowest index wins. accept_id_o then gives that index, and accept_vec_o gives 16'hFFFC minus two times that index.
- R5: A qualifying source that loses arbitration keeps its req_o bit. Once gdis_o is written back to 0, that source is accepted at a later sampling edge.
- R6: At the accepting edge, the pending bit of the winning source is cleared to 0.
- R7: At the accepting edge, gdis_o is set to 1, so further strobes accept nothing until software writes gdis_o back to 0.
- R8: If evt_i[k] is 1 at the same edge that accepts source k, req_o[k] stays 1.
- R9: With req_we_i high, each 0 bit of req_wdata_i clears the matching req_o bit. Each 1 bit leaves its req_o bit unchanged.
- R10: accept_o is high for exactly the one cycle after an accepting edge, and it is never high unless sample_i was high at the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_SRC | Per-source event pulses |
| req_we_i | input | 1 | Write strobe for the clear-only pending port |
| req_wdata_i | input | NUM_SRC | 0 bits clear pending bits; 1 bits have no effect |
| en_we_i | input | 1 | Write strobe for the enable mask |
| en_wdata_i | input | NUM_SRC | New enable mask |
| gdis_we_i | input | 1 | Write strobe for the global disable flag |
| gdis_wdata_i | input | 1 | New value of the global disable flag |
| sample_i | input | 1 | Instruction-boundary sampling strobe |
| accept_o | output | 1 | One-cycle acceptance pulse |
| accept_id_o | output | IDX_W | Index of the accepted source |
| accept_vec_o | output | 16 | Vector address of the accepted source |
| req_o | output | NUM_SRC | Pending bits |
| en_o | output | NUM_SRC | Enable mask |
| gdis_o | output | 1 | Global interrupt-disable flag |

## Verification
The bench walks a vector table of event patterns, enable masks and disable settings. It then targets cases that a subtly wrong arbiter would get wrong. One case is an event that lands on the accepting edge: a design that lets the clear win would lose that interrupt. Another is a loser that must survive the strobe: a design that cleared every qualifying bit, or picked the highest index, would service the wrong source or drop one. The bench also writes 1 bits to the clear port, which a design treating the port as a plain register would turn into new pending requests. Finally, it holds qualifying requests without a strobe, or with the flag set, to expose an arbiter that accepts outside instruction boundaries or ignores the global mask.

// File: rtl/irq_pkg.sv
// Package: shared constants and helpers for the interrupt arbiter.
// Assumes vectors are 16-bit, two bytes apart, growing downward with index.
package irq_pkg;
    localparam int unsigned IRQ_VEC_W = 16;

    // Vector address of a source: top minus two bytes per index step.
    function automatic logic [IRQ_VEC_W-1:0] irq_vec_addr(
        input logic [IRQ_VEC_W-1:0] top,
        input logic [IRQ_VEC_W-1:0] idx
    );
        return top - (idx << 1);
    endfunction
endpackage

// File: rtl/irq_req_bank.sv
// Module: sticky pending bits and enable mask for every source.
// Pending bits are set by events, cleared by acceptance or by the
// clear-only software port; a same-cycle event beats any clear.
// Assumes acc_clr_i is zero or one-hot.
module irq_req_bank #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               req_we_i,
    input  logic [NUM_SRC-1:0] req_wdata_i,
    input  logic [NUM_SRC-1:0] acc_clr_i,
    input  logic               en_we_i,
    input  logic [NUM_SRC-1:0] en_wdata_i,
    output logic [NUM_SRC-1:0] req_o,
    output logic [NUM_SRC-1:0] en_o
);
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] en_q;
    logic [NUM_SRC-1:0] sw_clr;

    // Software clear mask: a 0 written clears, a 1 is ignored.
    always_comb sw_clr = req_we_i ? ~req_wdata_i : '0;

    // Pending bits: keep, drop on clears, then events win.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q & ~acc_clr_i & ~sw_clr) | evt_i;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_we_i) en_q <= en_wdata_i;
    end

    assign req_o = req_q;
    assign en_o  = en_q;

    // R2: every event leaves its pending bit set after the edge.
    p_event_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(evt_i) & ~req_q) == '0));

    // R6: an accepted bit with no competing event is cleared.
    p_accept_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_clr_i & ~evt_i) != '0) |=> ((req_q & $past(acc_clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/irq_prio_pick.sv
// Module: fixed-priority picker, lowest index wins.
// Purely combinational; a ripple of "already taken" flags blocks
// every higher index once a lower one qualifies.
module irq_prio_pick #(
    parameter int unsigned NUM_SRC = 8,
    localparam int unsigned IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0] elig_i,
    output logic [NUM_SRC-1:0] grant_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               any_o
);
    logic [NUM_SRC:0] taken;

    assign taken[0] = 1'b0;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_slot
        assign grant_o[k]  = elig_i[k] & ~taken[k];
        assign taken[k+1]  = taken[k] | elig_i[k];
    end

    assign any_o = taken[NUM_SRC];

    // Encode the one-hot grant into an index.
    always_comb begin
        idx_o = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (grant_o[k]) idx_o = idx_o | IDX_W'(k);
        end
    end

    // R4: at most one winner, and only among qualifying sources.
    always_comb begin
        p_grant_onehot_r4: assert ($onehot0(grant_o));
        p_grant_subset_r4: assert ((grant_o & ~elig_i) == '0);
    end
endmodule

// File: rtl/irq_vec_map.sv
// Module: maps a source index to its constant vector address.
// Assumes vectors are packed two bytes apart below VEC_TOP.
module irq_vec_map
    import irq_pkg::*;
#(
    parameter int unsigned          IDX_W   = 3,
    parameter logic [IRQ_VEC_W-1:0] VEC_TOP = 16'hFFFC
) (
    input  logic [IDX_W-1:0]     idx_i,
    output logic [IRQ_VEC_W-1:0] vec_o
);
    // Address arithmetic on a zero-extended index.
    always_comb vec_o = irq_vec_addr(VEC_TOP, IRQ_VEC_W'(idx_i));
endmodule

// File: rtl/irq_accept_ctrl.sv
// Module: top of the interrupt request latch and arbiter.
// Holds the global disable flag, qualifies pending bits at sampling
// strobes, and registers the accept pulse, index and vector.
// Assumes sample_i is high for one cycle per instruction boundary.
module irq_accept_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned          NUM_SRC = 8,
    parameter logic [IRQ_VEC_W-1:0] VEC_TOP = 16'hFFFC,
    localparam int unsigned         IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   evt_i,
    input  logic                 req_we_i,
    input  logic [NUM_SRC-1:0]   req_wdata_i,
    input  logic                 en_we_i,
    input  logic [NUM_SRC-1:0]   en_wdata_i,
    input  logic                 gdis_we_i,
    input  logic                 gdis_wdata_i,
    input  logic                 sample_i,
    output logic                 accept_o,
    output logic [IDX_W-1:0]     accept_id_o,
    output logic [IRQ_VEC_W-1:0] accept_vec_o,
    output logic [NUM_SRC-1:0]   req_o,
    output logic [NUM_SRC-1:0]   en_o,
    output logic                 gdis_o
);
    logic [NUM_SRC-1:0]   req_w, en_w, elig, grant, acc_clr;
    logic [IDX_W-1:0]     win_idx;
    logic                 win_any, take;
    logic [IRQ_VEC_W-1:0] win_vec;
    logic                 gdis_q, accept_q;
    logic [IDX_W-1:0]     id_q;
    logic [IRQ_VEC_W-1:0] vec_q;

    irq_req_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .req_we_i   (req_we_i),
        .req_wdata_i(req_wdata_i),
        .acc_clr_i  (acc_clr),
        .en_we_i    (en_we_i),
        .en_wdata_i (en_wdata_i),
        .req_o      (req_w),
        .en_o       (en_w)
    );

    // Qualified set: pending, enabled and not globally masked.
    always_comb elig = req_w & en_w & {NUM_SRC{~gdis_q}};

    irq_prio_pick #(.NUM_SRC(NUM_SRC)) u_pick (
        .elig_i (elig),
        .grant_o(grant),
        .idx_o  (win_idx),
        .any_o  (win_any)
    );

    irq_vec_map #(.IDX_W(IDX_W), .VEC_TOP(VEC_TOP)) u_vec (
        .idx_i(win_idx),
        .vec_o(win_vec)
    );

    // Acceptance happens only on a strobe with a winner present.
    always_comb begin
        take    = sample_i & win_any;
        acc_clr = take ? grant : '0;
    end

    // Global disable flag: acceptance sets it, otherwise software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)         gdis_q <= 1'b1;
        else if (take)      gdis_q <= 1'b1;
        else if (gdis_we_i) gdis_q <= gdis_wdata_i;
    end

    // Accept pulse plus the held index and vector of the last winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_q <= 1'b0;
            id_q     <= '0;
            vec_q    <= '0;
        end else begin
            accept_q <= take;
            if (take) begin
                id_q  <= win_idx;
                vec_q <= win_vec;
            end
        end
    end

    assign accept_o     = accept_q;
    assign accept_id_o  = id_q;
    assign accept_vec_o = vec_q;
    assign req_o        = req_w;
    assign en_o         = en_w;
    assign gdis_o       = gdis_q;

    // R10: an accept pulse always follows a sampling strobe.
    p_accept_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(sample_i));

    // R7: the flag is set whenever an accept pulse is visible.
    p_accept_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> gdis_o);

    // R3: a strobe while globally masked yields no accept.
    p_masked_no_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && gdis_o) |=> !accept_o);

    // R3: a strobe with nothing pending and enabled yields no accept.
    p_empty_no_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_i && ((req_o & en_o) == '0)) |=> !accept_o);
endmodule

// File: tb/irq_accept_ctrl_test.sv
module irq_accept_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] evt_i, req_wdata_i, en_wdata_i;
    logic         req_we_i, en_we_i, gdis_we_i, gdis_wdata_i, sample_i;
    logic         accept_o, gdis_o;
    logic [2:0]   accept_id_o;
    logic [15:0]  accept_vec_o;
    logic [N-1:0] req_o, en_o;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_accept_ctrl uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .req_we_i(req_we_i), .req_wdata_i(req_wdata_i),
        .en_we_i(en_we_i), .en_wdata_i(en_wdata_i),
        .gdis_we_i(gdis_we_i), .gdis_wdata_i(gdis_wdata_i),
        .sample_i(sample_i), .accept_o(accept_o), .accept_id_o(accept_id_o),
        .accept_vec_o(accept_vec_o), .req_o(req_o), .en_o(en_o), .gdis_o(gdis_o)
    );

    // Table fields: evt[28:21] en[20:13] gdis[12] acc[11] id[10:8] req_after[7:0]
    localparam logic [28:0] TBL [8] = '{
        {8'h01, 8'hFF, 1'b0, 1'b1, 3'd0, 8'h00},
        {8'h28, 8'hFF, 1'b0, 1'b1, 3'd3, 8'h20},
        {8'h28, 8'hF7, 1'b0, 1'b1, 3'd5, 8'h08},
        {8'h80, 8'h7F, 1'b0, 1'b0, 3'd0, 8'h80},
        {8'hFF, 8'hFF, 1'b1, 1'b0, 3'd0, 8'hFF},
        {8'hC0, 8'hFF, 1'b0, 1'b1, 3'd6, 8'h80},
        {8'h00, 8'hFF, 1'b0, 1'b0, 3'd0, 8'h00},
        {8'h80, 8'h80, 1'b0, 1'b1, 3'd7, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_vec(input int idx);
        return 16'hFFFC - 16'(2 * idx);
    endfunction

    task automatic idle();
        evt_i = '0; req_we_i = 0; req_wdata_i = '1; en_we_i = 0; en_wdata_i = '0;
        gdis_we_i = 0; gdis_wdata_i = 0; sample_i = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    // Clear pending bits, load enables and the flag in one cycle.
    task automatic setup(input logic [N-1:0] en, input logic gd);
        req_we_i = 1; req_wdata_i = '0; en_we_i = 1; en_wdata_i = en;
        gdis_we_i = 1; gdis_wdata_i = gd;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        evt_i = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        idle();
        rst_n = 1;
        // R1: reset state
        chk("R1 req", 32'(req_o), 32'h0);
        chk("R1 en", 32'(en_o), 32'h0);
        chk("R1 gdis", 32'(gdis_o), 32'h1);
        chk("R1 accept", 32'(accept_o), 32'h0);

        // Table walk: R2 R3 R4 R6 R7 R10
        foreach (TBL[i]) begin
            setup(TBL[i][20:13], TBL[i][12]);
            evt_i = TBL[i][28:21];
            step();
            sample_i = 1;
            step();
            chk($sformatf("R3/R4 accept v%0d", i), 32'(accept_o), 32'(TBL[i][11]));
            if (TBL[i][11]) begin
                chk($sformatf("R4 id v%0d", i), 32'(accept_id_o), 32'(TBL[i][10:8]));
                chk($sformatf("R4 vec v%0d", i), 32'(accept_vec_o), 32'(exp_vec(int'(TBL[i][10:8]))));
            end
            chk($sformatf("R2/R6 req v%0d", i), 32'(req_o), 32'(TBL[i][7:0]));
            chk($sformatf("R7 gdis v%0d", i), 32'(gdis_o), 32'(TBL[i][12] | TBL[i][11]));
            step();
            chk($sformatf("R10 pulse v%0d", i), 32'(accept_o), 32'h0);
        end

        // R3: pending and enabled, but no strobe for several cycles
        setup(8'hFF, 1'b0);
        evt_i = 8'h10;
        step();
        for (int c = 0; c < 4; c++) begin
            chk("R3 no strobe accept", 32'(accept_o), 32'h0);
            step();
        end
        chk("R2 held pending", 32'(req_o), 32'h10);

        // R5: loser stays, then wins after the flag is reopened
        setup(8'hFF, 1'b0);
        evt_i = 8'h06;
        step();
        sample_i = 1;
        step();
        chk("R5 first winner", 32'(accept_id_o), 32'd1);
        chk("R5 loser kept", 32'(req_o), 32'h04);
        sample_i = 1;
        step();
        chk("R7 masked strobe", 32'(accept_o), 32'h0);
        gdis_we_i = 1; gdis_wdata_i = 0;
        step();
        sample_i = 1;
        step();
        chk("R5 second accept", 32'(accept_o), 32'h1);
        chk("R5 second winner", 32'(accept_id_o), 32'd2);
        chk("R5 vec", 32'(accept_vec_o), 32'(exp_vec(2)));
        chk("R5 req empty", 32'(req_o), 32'h00);

        // R8: event on the accepting edge keeps the bit pending
        setup(8'hFF, 1'b0);
        evt_i = 8'h01;
        step();
        evt_i = 8'h01;
        sample_i = 1;
        step();
        chk("R8 accept", 32'(accept_o), 32'h1);
        chk("R8 req kept", 32'(req_o), 32'h01);

        // R9: zeros clear, ones do nothing
        setup(8'h00, 1'b1);
        evt_i = 8'hFF;
        step();
        req_we_i = 1; req_wdata_i = 8'hF0;
        step();
        chk("R9 zeros clear", 32'(req_o), 32'hF0);
        req_we_i = 1; req_wdata_i = 8'hFF;
        step();
        chk("R9 ones ignored", 32'(req_o), 32'hF0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule